// File: doc/BRIEF.md
# Alternating-Clear Watchdog Timer

This block is a watchdog timer for a small processor core. A free-running prescaler divides the core clock, and a watchdog counter counts the prescaled ticks. If software does not restart the count in time, the block asks for help. While the core is running, that is a one-cycle reset request. While the core is halted, it is a one-cycle wake-up request instead. In both cases a time-out flag is set.

Software restarts the watchdog with two clear commands, called clear-A and clear-B. A static option chooses how they act. In single mode, either command restarts the watchdog at once. In paired mode, a restart needs one command of each kind, in alternation. The block keeps a record of the first half of the pair. A second copy of the same command does nothing. A halt command also restarts the watchdog, sets the power-down flag and clears the time-out flag. The core uses the two flags after a reset or wake-up to tell why it came back.

Top module: `alternatingClearWatchdog`

## Requirements
- R1: While `rstN` is low and right after release, `resetReq`, `wakeReq`, `toFlag` and `pdFlag` are all 0.
- R2: With no commands, a time-out happens exactly 2^(PRESC_W+BASE_EXP+PERIOD_SEL) clock edges after reset release or after the last restart. The timer then starts over and repeats with the same period. `PERIOD_SEL` is a 3-bit value.
- R3: A time-out while `halted` is 0 raises `resetReq` for exactly one cycle and sets `toFlag` to 1. `wakeReq` stays 0 and `pdFlag` keeps its value.
- R4: A time-out while `halted` is 1 raises `wakeReq` for exactly one cycle and sets `toFlag` to 1. `resetReq` stays 0 and `pdFlag` keeps its value.
- R5: A `haltStb` restarts the prescaler and the watchdog count, sets `pdFlag` to 1 and clears `toFlag` to 0.
- R6: With `dualClrMode` = 0, a single `clr1Stb` or `clr2Stb` restarts the timer and clears both flags.
- R7: With `dualClrMode` = 1, a restart that clears both flags happens only in three cases:
  - `clr2Stb` arrives while a clear-A is pending;
  - `clr1Stb` arrives while a clear-B is pending;
  - both strobes arrive in the same cycle.
  Any number of idle cycles may separate the two halves.
- R8: With `dualClrMode` = 1, repeating the pending command, or sending an unpaired one, has no effect. The flags keep their values and the time-out still comes at its original time.
- R9: A completed pair, a `haltStb` and single mode each erase the pending half. A clear-B sent right after any of them is therefore only a new first half.
- R10: When `haltStb` arrives together with a clear strobe, the halt effect of R5 applies.
- R11: A restart (clear or halt) sampled on the same edge that would end the period cancels that time-out. No request is raised and `toFlag` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| clr1Stb | input | 1 | One-cycle clear-A command |
| clr2Stb | input | 1 | One-cycle clear-B command |
| haltStb | input | 1 | One-cycle halt command |
| dualClrMode | input | 1 | 0: either command restarts; 1: alternating pair needed |
| halted | input | 1 | Core is in power-down |
| resetReq | output | 1 | One-cycle reset request after a time-out in normal operation |
| wakeReq | output | 1 | One-cycle wake-up request after a time-out while halted |
| toFlag | output | 1 | Time-out flag |
| pdFlag | output | 1 | Power-down flag |

## Verification
The bench builds the block with PRESC_W=2, BASE_EXP=2 and PERIOD_SEL=1, which gives a period of 32 edges. With this setting, several time-outs and restarts fit into short runs. Edge cases become reachable in a few cycles: a restart landing exactly on the expiry edge, and a time-out in both the halted and the running state. The small period also allows an exhaustive sweep in paired mode. The sweep covers every three-command sequence drawn from none, clear-A, clear-B and halt, with gaps between the commands. In every cycle the sweep is checked against an arithmetic model that tracks age, flags and the pending half.

// File: rtl/wdtPkg.sv
package wdtPkg;

  // Strobes sent from the control to the counting datapath
  typedef struct packed {
    logic restart;   // zero prescaler and watchdog count
    logic advance;   // let the prescaler run this cycle
  } wdtStrobes_t;

  // Record of the first half of a paired clear
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_A    = 2'd1,
    PEND_B    = 2'd2
  } pendHalf_t;

endpackage

// File: rtl/wdtClrSeq.sv
module wdtClrSeq
  import wdtPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic clr1Stb,
  input  logic clr2Stb,
  input  logic haltStb,
  input  logic dualClrMode,
  output logic clearGo
);

  pendHalf_t pendQ, pendD;

  always_comb begin
    clearGo = 1'b0;
    pendD   = pendQ;
    if (haltStb) begin
      pendD = PEND_NONE;
    end else if (!dualClrMode) begin
      clearGo = clr1Stb | clr2Stb;
      pendD   = PEND_NONE;
    end else begin
      if (clr1Stb && clr2Stb) begin
        clearGo = 1'b1;
      end else if (clr1Stb) begin
        clearGo = (pendQ == PEND_B);
      end else if (clr2Stb) begin
        clearGo = (pendQ == PEND_A);
      end
      if (clearGo) begin
        pendD = PEND_NONE;
      end else if (clr1Stb) begin
        pendD = PEND_A;
      end else if (clr2Stb) begin
        pendD = PEND_B;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= PEND_NONE;
    else       pendQ <= pendD;
  end

endmodule

// File: rtl/wdtDatapath.sv
module wdtDatapath
  import wdtPkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int CNT_W   = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t strobes,
  output logic        timeoutHit
);

  logic             tick;
  logic [CNT_W-1:0] cntQ;

  generate
    if (PRESC_W > 0) begin : g_presc
      logic [PRESC_W-1:0] prescQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                prescQ <= '0;
        else if (strobes.restart) prescQ <= '0;
        else if (strobes.advance) prescQ <= prescQ + 1'b1;
      end
      assign tick = strobes.advance & (&prescQ);
    end else begin : g_nopresc
      assign tick = strobes.advance;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cntQ <= '0;
    else if (strobes.restart) cntQ <= '0;
    else if (tick)            cntQ <= cntQ + 1'b1;
  end

  assign timeoutHit = tick & (&cntQ);

endmodule

// File: rtl/wdtControl.sv
module wdtControl
  import wdtPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        haltStb,
  input  logic        clearGo,
  input  logic        halted,
  input  logic        timeoutHit,
  output wdtStrobes_t strobes,
  output logic        resetReq,
  output logic        wakeReq,
  output logic        toFlag,
  output logic        pdFlag
);

  logic restartNow;
  logic expire;

  assign restartNow      = haltStb | clearGo;
  assign expire          = timeoutHit & ~restartNow;
  assign strobes.restart = restartNow;
  assign strobes.advance = ~restartNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toFlag   <= 1'b0;
      pdFlag   <= 1'b0;
      resetReq <= 1'b0;
      wakeReq  <= 1'b0;
    end else begin
      resetReq <= expire & ~halted;
      wakeReq  <= expire & halted;
      if (haltStb) begin
        pdFlag <= 1'b1;
        toFlag <= 1'b0;
      end else if (clearGo) begin
        pdFlag <= 1'b0;
        toFlag <= 1'b0;
      end else if (expire) begin
        toFlag <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/alternatingClearWatchdog.sv
module alternatingClearWatchdog
  import wdtPkg::*;
#(
  parameter int           PRESC_W    = 8,
  parameter int           BASE_EXP   = 4,
  parameter logic [2:0]   PERIOD_SEL = 3'd3
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr1Stb,
  input  logic clr2Stb,
  input  logic haltStb,
  input  logic dualClrMode,
  input  logic halted,
  output logic resetReq,
  output logic wakeReq,
  output logic toFlag,
  output logic pdFlag
);

  localparam int CNT_W = BASE_EXP + int'(PERIOD_SEL);

  wdtStrobes_t strobes;
  logic        clearGo;
  logic        timeoutHit;

  wdtClrSeq u_seq (
    .clk        (clk),
    .rstN       (rstN),
    .clr1Stb    (clr1Stb),
    .clr2Stb    (clr2Stb),
    .haltStb    (haltStb),
    .dualClrMode(dualClrMode),
    .clearGo    (clearGo)
  );

  wdtDatapath #(.PRESC_W(PRESC_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .timeoutHit(timeoutHit)
  );

  wdtControl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .haltStb   (haltStb),
    .clearGo   (clearGo),
    .halted    (halted),
    .timeoutHit(timeoutHit),
    .strobes   (strobes),
    .resetReq  (resetReq),
    .wakeReq   (wakeReq),
    .toFlag    (toFlag),
    .pdFlag    (pdFlag)
  );

endmodule

// File: rtl/alternatingClearWatchdog_chk.sv
module alternatingClearWatchdog_chk (
  input logic clk,
  input logic rstN,
  input logic clr1Stb,
  input logic clr2Stb,
  input logic haltStb,
  input logic dualClrMode,
  input logic halted,
  input logic resetReq,
  input logic wakeReq,
  input logic toFlag,
  input logic pdFlag
);

  a_r3_reset_req_sets_to: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> toFlag);

  a_r3_reset_req_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);

  a_r3_requests_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(resetReq && wakeReq));

  a_r4_wake_only_when_halted: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ($past(halted) && toFlag));

  a_r3_reset_only_when_running: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> !$past(halted));

  a_r5_halt_sets_pdf: assert property (@(posedge clk) disable iff (!rstN)
    haltStb |=> (pdFlag && !toFlag && !resetReq && !wakeReq));

  a_r6_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!dualClrMode && (clr1Stb || clr2Stb) && !haltStb) |=>
      (!toFlag && !pdFlag && !resetReq && !wakeReq));

  a_r7_pair_same_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (dualClrMode && clr1Stb && clr2Stb && !haltStb) |=> (!toFlag && !pdFlag));

endmodule

bind alternatingClearWatchdog alternatingClearWatchdog_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .clr1Stb    (clr1Stb),
  .clr2Stb    (clr2Stb),
  .haltStb    (haltStb),
  .dualClrMode(dualClrMode),
  .halted     (halted),
  .resetReq   (resetReq),
  .wakeReq    (wakeReq),
  .toFlag     (toFlag),
  .pdFlag     (pdFlag)
);

// File: tb/alternatingClearWatchdog_test.sv
module alternatingClearWatchdog_test;

  localparam int         PW = 2;
  localparam int         BE = 2;
  localparam logic [2:0] PS = 3'd1;
  localparam int         T  = 1 << (PW + BE + int'(PS));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clr1Stb = 1'b0, clr2Stb = 1'b0, haltStb = 1'b0;
  logic dualClrMode = 1'b0, halted = 1'b0;
  logic resetReq, wakeReq, toFlag, pdFlag;

  int runCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  int age = 0;
  int pend = 0;
  bit mTo = 1'b0, mPdf = 1'b0, eR = 1'b0, eW = 1'b0;

  always #2 clk = ~clk;

  alternatingClearWatchdog #(.PRESC_W(PW), .BASE_EXP(BE), .PERIOD_SEL(PS)) uut (
    .clk(clk), .rstN(rstN), .clr1Stb(clr1Stb), .clr2Stb(clr2Stb),
    .haltStb(haltStb), .dualClrMode(dualClrMode), .halted(halted),
    .resetReq(resetReq), .wakeReq(wakeReq), .toFlag(toFlag), .pdFlag(pdFlag)
  );

  task automatic check(input string tag);
    runCnt++;
    if ({resetReq, wakeReq, toFlag, pdFlag} !== {eR, eW, mTo, mPdf}) begin
      failCnt++;
      $display("FAIL %s at %0t: {rst,wake,to,pd} actual %b expected %b",
               tag, $time, {resetReq, wakeReq, toFlag, pdFlag}, {eR, eW, mTo, mPdf});
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input bit c1, input bit c2, input bit h, input string tag);
    bit ev;
    clr1Stb = c1; clr2Stb = c2; haltStb = h;
    @(posedge clk);
    ev = 1'b0; eR = 1'b0; eW = 1'b0;
    if (!h) begin
      if (!dualClrMode) begin
        ev = c1 | c2;
        pend = 0;
      end else begin
        if (c1 && c2)  ev = 1'b1;
        else if (c1)   ev = (pend == 2);
        else if (c2)   ev = (pend == 1);
        if (ev)        pend = 0;
        else if (c1)   pend = 1;
        else if (c2)   pend = 2;
      end
    end
    if (h) begin
      age = 0; mPdf = 1'b1; mTo = 1'b0; pend = 0;
    end else if (ev) begin
      age = 0; mPdf = 1'b0; mTo = 1'b0;
    end else begin
      age++;
      if (age == T) begin
        age = 0; mTo = 1'b1;
        if (halted) eW = 1'b1; else eR = 1'b1;
      end
    end
    @(negedge clk);
    clr1Stb = 1'b0; clr2Stb = 1'b0; haltStb = 1'b0;
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic cmd(input int c, input string tag);
    case (c)
      1: step(1'b1, 1'b0, 1'b0, tag);
      2: step(1'b0, 1'b1, 1'b0, tag);
      3: step(1'b0, 1'b0, 1'b1, tag);
      default: step(1'b0, 1'b0, 1'b0, tag);
    endcase
  endtask

  task automatic toEdgeBefore(input string tag);
    while (age != T - 1) step(1'b0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 in reset");
    rstN = 1'b1;
    check("R1 after release");

    // R2 / R3: free-running period in normal operation
    idle(3 * T + 4, "R2 R3 free run");

    // R6: single-mode clears of either kind
    dualClrMode = 1'b0;
    idle(10, "R6 lead");
    step(1'b1, 1'b0, 1'b0, "R6 clear-A");
    idle(T - 5, "R6 after clear-A");
    step(1'b0, 1'b1, 1'b0, "R6 clear-B");
    idle(T + 3, "R6 after clear-B");

    // R11: restart on the expiry edge cancels the time-out
    toEdgeBefore("R11 approach");
    step(1'b1, 1'b0, 1'b0, "R11 clear on expiry edge");
    idle(5, "R11 after");
    toEdgeBefore("R11 approach halt");
    step(1'b0, 1'b0, 1'b1, "R11 halt on expiry edge");

    // R5 / R4: halt then time-out while halted
    halted = 1'b1;
    idle(2 * T + 3, "R4 halted time-out");
    step(1'b0, 1'b0, 1'b1, "R5 halt again");
    idle(7, "R5 after halt");
    halted = 1'b0;
    idle(T, "R3 time-out after halt");

    // R10: halt with clear in the same cycle
    step(1'b1, 1'b1, 1'b1, "R10 halt plus clears");
    idle(4, "R10 after");

    // R7: paired mode
    dualClrMode = 1'b1;
    idle(3, "R7 lead");
    step(1'b1, 1'b0, 1'b0, "R7 first half A");
    idle(5, "R7 gap");
    step(1'b0, 1'b1, 1'b0, "R7 second half B");
    idle(6, "R7 after");
    step(1'b0, 1'b1, 1'b0, "R7 first half B");
    step(1'b1, 1'b0, 1'b0, "R7 second half A");
    idle(T + 2, "R7 run out");
    step(1'b1, 1'b1, 1'b0, "R7 both same cycle");
    idle(3, "R7 after both");

    // R8: repeated command has no effect
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 1'b0, 1'b0, "R8 repeat A");
      idle(4, "R8 gap");
    end
    idle(T, "R8 time-out still comes");

    // R9: pending half erased by halt and by a completed pair
    step(1'b1, 1'b0, 1'b0, "R9 A pending");
    step(1'b0, 1'b0, 1'b1, "R9 halt erases");
    step(1'b0, 1'b1, 1'b0, "R9 B after halt");
    idle(4, "R9 gap");
    step(1'b1, 1'b0, 1'b0, "R9 A");
    step(1'b0, 1'b1, 1'b0, "R9 B completes");
    idle(T - 3, "R9 wait");
    step(1'b0, 1'b1, 1'b0, "R9 B after completion");
    idle(6, "R9 observe");
    dualClrMode = 1'b0;
    step(1'b1, 1'b0, 1'b0, "R9 single-mode clear");
    dualClrMode = 1'b1;
    step(1'b0, 1'b1, 1'b0, "R9 B after mode switch");
    idle(T, "R9 observe switch");

    // R7 R8 exhaustive three-command sweep in paired mode
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          cmd(a, "R7 R8 sweep");
          idle(2, "R7 R8 sweep gap");
          cmd(b, "R7 R8 sweep");
          idle(1, "R7 R8 sweep gap");
          cmd(c, "R7 R8 sweep");
          idle(5, "R7 R8 sweep tail");
        end
    idle(T + 2, "R2 final period");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule